// File: doc/BRIEF.md
# Soft-Start Reference Step Sequencer

This block paces the start-up of a boost regulator. On each enable it raises a 5-bit reference code from zero towards a target level, one level per dwell period. The dwell is measured in ticks of a slow timing strobe, so the block can run on a fast system clock. Alongside the ramp it raises a flag that asks the switch stage to halve its current limit. The flag covers a fixed window of ticks near the start and is timed apart from the ramp.

The code can take 32 levels, 0 to 31. When the target is below full scale, the ramp stops at the target and the done flag rises early. Once the ramp is done, the code follows any target change on the next clock with no new ramp. If the target drops mid-ramp to or below the level already reached, the ramp ends and the code jumps to the new target. Dropping enable clears everything. The next enable starts again from level zero with a fresh current-limit window.

Top module: `sstart_seq`

## Requirements
- R1: While enable is low, and on the clock after it falls (including mid-ramp), ramp_code is 0 and ramp_done and half_limit are both 0. All are 0 after reset.
- R2: On the first clock edge that sees enable high after a disabled period, ramp_code becomes 0 and half_limit becomes 1. ramp_done becomes 1 at that edge only if target is 0.
- R3: While ramping, the internal level rises by one after every STEP_TICKS edges on which tick is high. Edges with tick low do not count.
- R4: Levels run from 0 to 31 (32 levels). A target of 31 is reached, with ramp_done set, on the edge of tick number 31*STEP_TICKS counted after activation.
- R5: ramp_code equals the level while the level is below target. When the level reaches target, ramp_code equals target and ramp_done rises on the same edge.
- R6: While ramp_done is set, ramp_code takes the target value seen at each clock edge, for raises and drops alike, without ramping.
- R7: If target is changed mid-ramp to a value at or below the current level, then on the next edge ramp_done rises and ramp_code equals the new target.
- R8: half_limit stays high from activation until HALF_TICKS ticks have been counted, then falls and stays low until the next activation. This is independent of the ramp state.
- R9: Every activation that follows a disabled period restarts the ramp from level 0 and restarts the half-limit window.
- R10: Once set, ramp_done stays set for as long as enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timing strobe that paces dwell and window counting |
| enable | input | 1 | High to run; low forces shutdown and clears state |
| target | input | 5 | Requested final reference level (0..31) |
| ramp_code | output | 5 | Present reference code |
| ramp_done | output | 1 | Ramp has reached the target |
| half_limit | output | 1 | Request for halved switch current limit |

## Verification
Every target from 0 to 31 is ramped with a tick on each cycle. This separates the clamp-and-early-done path from the full-scale ramp. It also shows the half-limit window running on after the ramp ends, or ending before it. A run with one tick every third cycle and a run with a long gap in tick show that only ticked edges advance the counters. Target changes after done, a target lowered mid-ramp, and enable dropped mid-ramp then raised again cover the direct-follow, early-finish and restart paths.

// File: rtl/sstart_pkg.sv
`timescale 1ns/1ps
package sstart_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_RAMP = 2'd1,
        PH_HOLD = 2'd2
    } sstart_phase_e;

endpackage

// File: rtl/sstart_tick_timer.sv
`timescale 1ns/1ps
module sstart_tick_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    generate
        if (LIMIT <= 1) begin : g_single
            assign expire = run;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                expire = run && (cnt_q == LAST);
                cnt_d  = cnt_q;
                if (clr)
                    cnt_d = '0;
                else if (run)
                    cnt_d = expire ? '0 : cnt_q + CW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate

endmodule

// File: rtl/sstart_level_sel.sv
`timescale 1ns/1ps
module sstart_level_sel #(
    parameter int LEVEL_W = 5
) (
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] target,
    output logic [LEVEL_W-1:0] code,
    output logic               reached
);
    always_comb begin
        reached = (level >= target);
        code    = reached ? target : level;
    end
endmodule

// File: rtl/sstart_seq.sv
`timescale 1ns/1ps
module sstart_seq #(
    parameter int LEVEL_W    = 5,
    parameter int STEP_TICKS = 256,
    parameter int HALF_TICKS = 6000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               enable,
    input  logic [LEVEL_W-1:0] target,
    output logic [LEVEL_W-1:0] ramp_code,
    output logic               ramp_done,
    output logic               half_limit
);
    import sstart_pkg::*;

    typedef struct packed {
        sstart_phase_e      phase;
        logic [LEVEL_W-1:0] level;
        logic [LEVEL_W-1:0] code;
        logic               half;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic step_run, step_clr, step_exp;
    logic half_run, half_clr, half_exp;
    logic [LEVEL_W-1:0] level_nxt;
    logic [LEVEL_W-1:0] sel_code;
    logic               sel_reached;

    assign step_run = tick && enable && (st_q.phase == PH_RAMP);
    assign step_clr = !enable || (st_q.phase != PH_RAMP);
    assign half_run = tick && enable && st_q.half;
    assign half_clr = !enable || (st_q.phase == PH_OFF);

    sstart_tick_timer #(.LIMIT(STEP_TICKS)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (step_clr),
        .run    (step_run),
        .expire (step_exp)
    );

    sstart_tick_timer #(.LIMIT(HALF_TICKS)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (half_clr),
        .run    (half_run),
        .expire (half_exp)
    );

    assign level_nxt = st_q.level + LEVEL_W'(step_exp);

    sstart_level_sel #(.LEVEL_W(LEVEL_W)) u_sel (
        .level   (level_nxt),
        .target  (target),
        .code    (sel_code),
        .reached (sel_reached)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = (target == '0) ? PH_HOLD : PH_RAMP;
                    st_d.level = '0;
                    st_d.code  = '0;
                    st_d.half  = 1'b1;
                end
                PH_RAMP: begin
                    st_d.level = level_nxt;
                    st_d.code  = sel_code;
                    st_d.phase = sel_reached ? PH_HOLD : PH_RAMP;
                    st_d.half  = st_q.half && !half_exp;
                end
                PH_HOLD: begin
                    st_d.code = target;
                    st_d.half = st_q.half && !half_exp;
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ramp_code  = st_q.code;
    assign ramp_done  = (st_q.phase == PH_HOLD);
    assign half_limit = st_q.half;

endmodule

// File: rtl/sstart_seq_chk.sv
`timescale 1ns/1ps
module sstart_seq_chk #(
    parameter int LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [LEVEL_W-1:0] target,
    input logic [LEVEL_W-1:0] ramp_code,
    input logic               ramp_done,
    input logic               half_limit
);
    // R1
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ramp_code == '0 && !ramp_done && !half_limit));

    // R6
    hold_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ramp_done) |=> (ramp_code == $past(target)));

    // R10
    done_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ramp_done) |=> ramp_done);

    // R5
    ramp_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !ramp_done) |=> (ramp_done || ramp_code >= $past(ramp_code)));

    // R8
    window_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !half_limit) |=> !half_limit);
endmodule

bind sstart_seq sstart_seq_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .target     (target),
    .ramp_code  (ramp_code),
    .ramp_done  (ramp_done),
    .half_limit (half_limit)
);

// File: tb/sstart_seq_tb.sv
`timescale 1ns/1ps
module sstart_seq_tb;
    localparam int STEP = 4;
    localparam int HALF = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       enable = 1'b0;
    logic [4:0] target = 5'd31;
    logic [4:0] ramp_code;
    logic       ramp_done;
    logic       half_limit;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    bit model_on = 1'b0;

    // reference model state
    bit m_act = 0;
    bit m_done = 0;
    int m_ticks = 0;
    int e_code = 0;
    bit e_done = 0;
    bit e_half = 0;

    always #2.5 clk = ~clk;

    sstart_seq #(.LEVEL_W(5), .STEP_TICKS(STEP), .HALF_TICKS(HALF)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .enable     (enable),
        .target     (target),
        .ramp_code  (ramp_code),
        .ramp_done  (ramp_done),
        .half_limit (half_limit)
    );

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_act = 0; m_done = 0; m_ticks = 0;
            e_code = 0; e_done = 0; e_half = 0;
        end else if (!m_act) begin
            m_act = 1; m_ticks = 0; m_done = (target == 0);
            e_code = 0; e_done = m_done; e_half = 1;
        end else begin
            if (tick) m_ticks = m_ticks + 1;
            if (!m_done && (m_ticks / STEP) >= int'(target)) m_done = 1;
            e_code = m_done ? int'(target) : m_ticks / STEP;
            e_done = m_done;
            e_half = (m_ticks < HALF);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk(cur_req, ramp_code, e_code);
            chk("R5", ramp_done, e_done);
            chk("R8", half_limit, e_half);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1", ramp_code, 0);
        chk("R1", ramp_done, 0);
        chk("R1", half_limit, 0);
        model_on = 1'b1;

        // R5 / R9: every target, tick each cycle, restart each time
        for (int t = 0; t < 32; t++) begin
            cur_req = "R5";
            target = 5'(t);
            enable = 1'b1;
            cyc(1);
            // R2: activation values
            chk("R2", ramp_code, 0);
            chk("R2", half_limit, 1);
            chk("R2", ramp_done, (t == 0) ? 1 : 0);
            cyc((t + 1) * STEP + 45);
            cur_req = "R9";
            enable = 1'b0;
            cyc(2);
        end

        // R4: full-scale edge timing
        cur_req = "R4";
        target = 5'd31;
        enable = 1'b1;
        cyc(31 * STEP);
        chk("R4", ramp_done, 0);
        chk("R4", ramp_code, 30);
        cyc(1);
        chk("R4", ramp_done, 1);
        chk("R4", ramp_code, 31);

        // R6 / R10: target follows directly once done
        cur_req = "R6";
        target = 5'd10; cyc(1);
        chk("R6", ramp_code, 10);
        target = 5'd25; cyc(3);
        chk("R6", ramp_code, 25);
        target = 5'd0; cyc(3);
        chk("R10", ramp_done, 1);
        enable = 1'b0; cyc(2);

        // R3: sparse ticks
        cur_req = "R3";
        target = 5'd31;
        enable = 1'b1;
        for (int i = 0; i < 31 * STEP * 3 + 10; i++) begin
            tick = (i % 3 == 0);
            cyc(1);
        end
        tick = 1'b1;
        enable = 1'b0; cyc(2);

        // R3: long tick gap mid-ramp freezes the level
        enable = 1'b1;
        cyc(10);
        tick = 1'b0;
        cyc(20);
        chk("R3", ramp_code, 2);
        tick = 1'b1;
        cyc(10);
        enable = 1'b0; cyc(2);

        // R7: target lowered under the reached level
        cur_req = "R7";
        target = 5'd31;
        enable = 1'b1;
        cyc(50);
        target = 5'd5;
        cyc(1);
        chk("R7", ramp_done, 1);
        chk("R7", ramp_code, 5);
        cyc(5);

        // R9: drop mid-ramp and restart
        cur_req = "R9";
        enable = 1'b0;
        target = 5'd20;
        cyc(1);
        chk("R9", ramp_code, 0);
        enable = 1'b1;
        cyc(30);
        enable = 1'b0;
        cyc(1);
        chk("R1", half_limit, 0);
        enable = 1'b1;
        cyc(1);
        chk("R9", ramp_code, 0);
        chk("R9", half_limit, 1);
        cyc(100);
        enable = 1'b0;
        cyc(3);
        model_on = 1'b0;
        summary();
    end
endmodule